// File: doc/BRIEF.md
# Composite Sync Pulse Classifier

This block watches the one-bit output of a sync-level comparator on a composite video feed. It samples the bit on a free-running clock and finds each falling edge of the sync tip. It then counts how many clock samples the level stays low before the next rising edge. The count sorts the pulse into one of three kinds: an ordinary horizontal line sync, a narrow equalizing pulse, or a wide vertical serration pulse. Counts that fall between the bands are dropped.

Every ordinary line sync advances a scanline counter. It also raises a one-clock line-start strobe and a render-enable level, which together start the downstream active-video timer. A narrow or wide pulse marks the vertical interval. It sends the scanline counter back to zero and withdraws render enable, so nothing is drawn over the vertical interval.

The three width limits and the glitch-filter length are run-time inputs. All widths are counted in sample-clock periods.

Top module: `sync_classifier`

## Requirements
- R1: After reset, pulse_class is 2'b00, line_num is 0, line_start is 0 and render_en is 0.
- R2: The width of a pulse is the number of filtered low samples from the falling edge up to the next rising edge. A width below thr_short is a short pulse, and pulse_class becomes 2'b10. A width from thr_short to thr_norm inclusive is a line pulse, and pulse_class becomes 2'b01. A width above thr_long is a long pulse, and pulse_class becomes 2'b11.
- R3: A pulse whose width is above thr_norm and at or below thr_long, and which has not saturated the counter, is ignored. pulse_class and line_num keep their values and no line_start is issued.
- R4: A line pulse increments line_num by one and drives line_start high for exactly one clock. That clock is the cycle after the rising edge of the pulse is seen.
- R5: A short or long pulse sets line_num to 0 and clears render_en.
- R6: render_en rises together with line_start. It drops at the next filtered falling edge of sync, and it is low throughout the pulse that follows.
- R7: The width counter saturates at 2^CW-1. A saturated count is classed as long, even when thr_long equals 2^CW-1.
- R8: line_num wraps from 1023 to 0 on a line pulse when no short or long pulse has intervened.
- R9: The filtered level takes a new value only after the synchronized input has held that value for filt_len consecutive samples. With filt_len of 0 there is no filtering. A low glitch shorter than filt_len produces no event. A high glitch shorter than filt_len inside a pulse is bridged, and the widths on either side of it add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_in | input | 1 | Raw comparator output, low during sync |
| filt_len | input | 3 | Glitch filter length in samples, 0 to 7 |
| thr_short | input | CW | Widths below this value are short pulses |
| thr_norm | input | CW | Upper inclusive limit of a line pulse |
| thr_long | input | CW | Widths above this value are long pulses |
| pulse_class | output | 2 | Class of the last accepted pulse: 01 line, 10 short, 11 long |
| line_num | output | 10 | Scanline counter |
| line_start | output | 1 | One-clock strobe after each line pulse |
| render_en | output | 1 | Arms the active-video renderer |

## Verification
A wrong width count, or a threshold compared off by one, shows up as a wrong pulse_class and line_num. This appears one clock after the rising edge of the pulse whose width sits at a band edge, which is why the widths are swept through every boundary. A filter or synchronizer fault changes the measured width or lets a glitch through. Either one appears as a spurious or missing line_start within a few clocks of the glitch. A stuck or non-wrapping line counter takes a full run of 1024 line pulses to reveal, so one such run is included.

// File: rtl/sync_classifier.sv
module sync_classifier #(
  parameter int CW = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_in,
  input  logic [2:0]        filt_len,
  input  logic [CW-1:0]     thr_short,
  input  logic [CW-1:0]     thr_norm,
  input  logic [CW-1:0]     thr_long,
  output logic [1:0]        pulse_class,
  output logic [LINE_W-1:0] line_num,
  output logic              line_start,
  output logic              render_en
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [1:0] C_LINE = 2'b01, C_SHORT = 2'b10, C_LONG = 2'b11;

  logic s1, s2, fq, prev, in_pulse;
  logic [2:0] run;
  logic [CW-1:0] cnt;
  logic lvl, fall, rise, sat, is_long, is_short, is_line;

  assign lvl      = (filt_len == 3'd0) ? s2 : fq;
  assign fall     = prev & ~lvl;
  assign rise     = in_pulse & lvl & ~prev;
  assign sat      = (cnt == CNT_MAX);
  assign is_long  = sat || (cnt > thr_long);
  assign is_short = !is_long && (cnt < thr_short);
  assign is_line  = !is_long && (cnt >= thr_short) && (cnt <= thr_norm);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; fq <= 1'b1; run <= '0;
    end else begin
      s1 <= comp_in;
      s2 <= s1;
      if (s2 == fq) run <= '0;
      else if ({1'b0, run} + 4'd1 >= {1'b0, filt_len}) begin
        fq  <= s2;
        run <= '0;
      end else run <= run + 3'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev <= 1'b1; in_pulse <= 1'b0; cnt <= '0;
      pulse_class <= 2'b00; line_num <= '0;
      line_start <= 1'b0; render_en <= 1'b0;
    end else begin
      prev       <= lvl;
      line_start <= 1'b0;
      if (fall) begin
        in_pulse  <= 1'b1;
        cnt       <= {{(CW-1){1'b0}}, 1'b1};
        render_en <= 1'b0;
      end else if (in_pulse && !lvl) begin
        if (!sat) cnt <= cnt + 1'b1;
      end else if (rise) begin
        in_pulse <= 1'b0;
        if (is_long || is_short) begin
          pulse_class <= is_long ? C_LONG : C_SHORT;
          line_num    <= '0;
          render_en   <= 1'b0;
        end else if (is_line) begin
          pulse_class <= C_LINE;
          line_num    <= line_num + 1'b1;
          line_start  <= 1'b1;
          render_en   <= 1'b1;
        end
      end
    end
endmodule

// File: rtl/sync_classifier_chk.sv
module sync_classifier_chk #(
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pulse_class,
  input logic [LW-1:0] line_num,
  input logic          line_start,
  input logic          render_en
);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);
  // R4
  strobe_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (line_num == LW'($past(line_num) + 1'b1)));
  // R8
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (line_num == $past(line_num)) || (line_num == '0) ||
             (line_num == LW'($past(line_num) + 1'b1)));
  // R6
  render_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    render_en |-> (pulse_class == 2'b01));
  // R6
  strobe_render_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> render_en);
  // R5
  vsync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_class[1] |-> (line_num == '0) && !render_en);
endmodule

bind sync_classifier sync_classifier_chk #(.LW(LINE_W)) chk (
  .clk(clk), .rst_n(rst_n), .pulse_class(pulse_class),
  .line_num(line_num), .line_start(line_start), .render_en(render_en));

// File: tb/sync_classifier_test.sv
module sync_classifier_test;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0, comp_in = 1;
  logic [2:0] filt_len = 0;
  logic [CW-1:0] thr_short = 20, thr_norm = 40, thr_long = 60;
  logic [1:0] pulse_class;
  logic [9:0] line_num;
  logic line_start, render_en;

  int total = 0, bad = 0, starts = 0;
  int e_cls = 0, e_ln = 0, e_re = 0;
  bit done = 0;

  sync_classifier #(.CW(CW), .LINE_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .comp_in(comp_in), .filt_len(filt_len),
    .thr_short(thr_short), .thr_norm(thr_norm), .thr_long(thr_long),
    .pulse_class(pulse_class), .line_num(line_num),
    .line_start(line_start), .render_en(render_en));

  always #4 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cls_of(int w);
    if (w >= 255 || w > thr_long) return 3;
    if (w < thr_short) return 2;
    if (w <= thr_norm) return 1;
    return 0;
  endfunction

  task automatic lowfor(int n);
    comp_in = 0;
    repeat (n) @(negedge clk);
    comp_in = 1;
  endtask

  task automatic tail(int gap);
    starts = 0;
    repeat (gap) begin
      @(negedge clk);
      if (line_start) starts++;
    end
  endtask

  task automatic expect_state(string tag, int exp_starts);
    chk(pulse_class == e_cls, {tag, " class"}, pulse_class, e_cls);
    chk(line_num == e_ln, {tag, " line_num"}, line_num, e_ln);
    chk(render_en == e_re, {tag, " render_en"}, render_en, e_re);
    chk(starts == exp_starts, {tag, " strobes"}, starts, exp_starts);
  endtask

  task automatic pulse(int w, int gap);
    int c;
    c = cls_of(w);
    comp_in = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (i == 14) chk(render_en == 0, "R6 low during pulse", render_en, 0);
    end
    comp_in = 1;
    tail(gap);
    e_re = 0;
    if (c == 1) begin e_cls = 1; e_ln = (e_ln + 1) % 1024; e_re = 1; end
    else if (c >= 2) begin e_cls = c; e_ln = 0; end
    expect_state(c == 1 ? "R2 R4 line" : c == 0 ? "R3 ignored" : "R2 R5 vsync",
                 c == 1 ? 1 : 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pulse_class == 0, "R1 class", pulse_class, 0);
    chk(line_num == 0, "R1 line_num", line_num, 0);
    chk(line_start == 0, "R1 strobe", line_start, 0);
    chk(render_en == 0, "R1 render_en", render_en, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 R3 R4 R5: every width across all band edges, no filter
    for (int w = 1; w <= 80; w++) pulse(w, 30);

    // R9: sweep with a 5-sample filter; widths are preserved
    filt_len = 5;
    for (int w = 5; w <= 80; w += 3) pulse(w, 40);

    // R9: glitch rejection and bridging with filt_len 3
    filt_len = 3;
    pulse(30, 40);
    lowfor(2); tail(40);
    expect_state("R9 glitch dropped", 0);
    lowfor(15); repeat (2) @(negedge clk); lowfor(15); tail(40);
    e_ln = (e_ln + 1) % 1024; e_cls = 1; e_re = 1;
    expect_state("R9 bridged line", 1);

    // R7: saturation versus a threshold at full scale
    filt_len = 0;
    thr_long = 255;
    pulse(200, 30);
    pulse(300, 30);
    thr_long = 60;

    // R8: wrap of the scanline counter
    pulse(5, 30);
    for (int k = 0; k < 1023; k++) pulse(25, 8);
    chk(line_num == 1023, "R8 top", line_num, 1023);
    pulse(25, 8);
    chk(line_num == 0 && pulse_class == 1, "R8 wrap", line_num, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule